// File: doc/BRIEF.md
# Masked-Write General-Purpose I/O Port

This block drives and samples a bank of 32 general-purpose pins through a small 32-bit register bus. The bus has an address, write data, a single-cycle write strobe and a combinational read-data return. Each pin's direction is changed by writing ones to one of two write-one-to-act registers: one turns pins into outputs and the other turns them back into inputs. Bits written as zero leave their pins untouched, so software never has to read a register, modify it and write it back.

Output levels are held in a 32-bit latch that is written through two half-word update registers. Each update word carries sixteen new values in its low half and a sixteen-bit per-pin write mask in its high half. Pins whose mask bit is clear keep their stored level. The latch drives the pad output at all times, whatever the pin's direction. A level can therefore be loaded while the pin is still an input, and it appears on the pad without a glitch when the pin is later made an output. Pad inputs pass through a two-flop synchronizer. The synchronized levels are read back as one word.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all zero), the output latch (`pad_out`) is all zero, and the direction and input words both read as zero while the pads are low.
- R2: A write to offset 0x00 makes every pin whose data bit is 1 an output. Pins whose data bit is 0 keep their direction.
- R3: A write to offset 0x04 makes every pin whose data bit is 1 an input. Pins whose data bit is 0 keep their direction.
- R4: A write to offset 0x08 updates pins 0..15. For each n in 0..15, data bit 16+n enables pin n and data bit n is its new level. Pins whose enable bit is 0 keep their level.
- R5: A write to offset 0x0C updates pins 16..31 with the same layout: data bit 16+n enables pin 16+n and data bit n is its new level. Pins whose enable bit is 0 keep their level.
- R6: A read of offset 0x10 returns the pad input levels, one bit per pin with bit i for pin i, through a two-flop synchronizer. A pad change shows up after the second rising clock edge and not after the first.
- R7: A read of offset 0x04 returns the direction vector (1 = output), and that vector equals `pad_oe`.
- R8: `pad_out` follows the output latch whatever the direction. A level loaded while a pin is an input stays unchanged on `pad_out` in the cycle the pin becomes an output.
- R9: Reads of any offset other than 0x04 and 0x10 return zero, including the write-only offsets 0x00, 0x08 and 0x0C. Writes to offsets other than 0x00, 0x04, 0x08 and 0x0C change neither direction nor output levels.
- R10: While `bus_wr` is low, no address or data value changes the direction or the output levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pin input levels |
| pad_out | output | 32 | Pin output levels from the output latch |
| pad_oe | output | 32 | Pin output enables (1 = drive) |

## Verification
A wrong direction or output-latch bit is visible on `pad_oe` or `pad_out` one clock edge after the write that caused it. The bench checks both buses after every write. Mask handling is checked by keeping an arithmetic model of the latch over a long series of mixed masked writes, so a bit that is taken or dropped against its mask is caught at the next check. A synchronizer that is too short or too long shows up as input data read one cycle early or one cycle late. Decode faults show up as non-zero reads of unmapped offsets, or as pin state that changes after writes that should be ignored.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Register offsets; software depends on these exact values.
   localparam int unsigned OFS_DIR_SET = 32'h00;
   localparam int unsigned OFS_DIR_CLR = 32'h04;
   localparam int unsigned OFS_OUT_LO  = 32'h08;
   localparam int unsigned OFS_OUT_HI  = 32'h0C;
   localparam int unsigned OFS_IN_LVL  = 32'h10;

   typedef enum logic [2:0] {
      SEL_NONE    = 3'd0,
      SEL_DIR_SET = 3'd1,
      SEL_DIR_CLR = 3'd2,
      SEL_OUT_LO  = 3'd3,
      SEL_OUT_HI  = 3'd4,
      SEL_IN_LVL  = 3'd5
   } reg_sel_e;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dir_vec,
   input  logic [DATA_W-1:0] in_vec,
   output reg_sel_e          sel,
   output logic [DATA_W-1:0] rdata
);

   localparam int MIN_ADDR_W = 5;

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_addr_chk
         $error("gpio_reg_decode: ADDR_W too small for register map");
      end
   endgenerate

   always_comb begin
      unique case (32'(addr))
         OFS_DIR_SET: sel = SEL_DIR_SET;
         OFS_DIR_CLR: sel = SEL_DIR_CLR;
         OFS_OUT_LO:  sel = SEL_OUT_LO;
         OFS_OUT_HI:  sel = SEL_OUT_HI;
         OFS_IN_LVL:  sel = SEL_IN_LVL;
         default:     sel = SEL_NONE;
      endcase
   end

   // Only direction and input level are readable; everything else is zero.
   always_comb begin
      rdata = '0;
      if (sel == SEL_DIR_CLR) rdata = dir_vec;
      if (sel == SEL_IN_LVL)  rdata = in_vec;
   end

   // R9: a select other than the two readable ones returns zero.
   always_comb begin
      if (sel != SEL_DIR_CLR && sel != SEL_IN_LVL)
         a_unread_zero_r9: assert (rdata == '0 || $isunknown(addr));
   end

endmodule

// File: rtl/gpio_dir_ctrl.sv
module gpio_dir_ctrl #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_stb,
   input  logic                clr_stb,
   input  logic [NUM_PINS-1:0] bits,
   output logic [NUM_PINS-1:0] dir_q
);

   generate
      if (NUM_PINS < 1) begin : g_pin_chk
         $error("gpio_dir_ctrl: NUM_PINS must be positive");
      end
   endgenerate

   logic [NUM_PINS-1:0] dir_d;

   always_comb begin
      dir_d = dir_q;
      if (set_stb)      dir_d = dir_q | bits;
      else if (clr_stb) dir_d = dir_q & ~bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_q <= '0;
      else        dir_q <= dir_d;
   end

   // R2: written ones become outputs, others keep their state.
   p_set_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> (((dir_q & $past(bits)) == $past(bits)) &&
                   ((dir_q & ~$past(bits)) == ($past(dir_q) & ~$past(bits)))));

   // R3: written ones become inputs, others keep their state.
   p_clr_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> (((dir_q & $past(bits)) == '0) &&
                   ((dir_q & ~$past(bits)) == ($past(dir_q) & ~$past(bits)))));

   // R10: no strobe, no change.
   p_dir_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !set_stb && !clr_stb) |=> $stable(dir_q));

   p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_stb && clr_stb));

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int NUM_PINS = 32,
   parameter int HALF_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic [2*HALF_W-1:0] wdata,
   output logic [NUM_PINS-1:0] out_q
);

   localparam int N_HALVES = NUM_PINS / HALF_W;

   generate
      if (N_HALVES * HALF_W != NUM_PINS || N_HALVES != 2) begin : g_geom_chk
         $error("gpio_out_latch: NUM_PINS must be exactly two halves of HALF_W");
      end
   endgenerate

   logic [HALF_W-1:0] upd_val;
   logic [HALF_W-1:0] upd_msk;
   logic [1:0]        half_wr;

   assign upd_val = wdata[HALF_W-1:0];
   assign upd_msk = wdata[2*HALF_W-1:HALF_W];
   assign half_wr = {wr_hi, wr_lo};

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF_W-1:0] lvl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= '0;
         end else if (half_wr[h]) begin
            lvl_q <= (lvl_q & ~upd_msk) | (upd_val & upd_msk);
         end
      end

      assign out_q[h*HALF_W +: HALF_W] = lvl_q;

      // R4 (half 0) / R5 (half 1): enabled bits take the value, others hold.
      p_mask_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
         half_wr[h] |=>
            (((out_q[h*HALF_W +: HALF_W] ^ $past(upd_val)) & $past(upd_msk)) == '0) &&
            (((out_q[h*HALF_W +: HALF_W] ^ $past(out_q[h*HALF_W +: HALF_W]))
               & ~$past(upd_msk)) == '0));

      // R10: halves hold without their strobe.
      p_half_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_n && !half_wr[h]) |=> $stable(out_q[h*HALF_W +: HALF_W]));
   end

   p_one_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_lo && wr_hi));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_PINS = 32,
   parameter int STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] lvl_sync
);

   generate
      if (STAGES < 2) begin : g_stage_chk
         $error("gpio_in_sync: at least two stages are needed");
      end
   endgenerate

   logic [NUM_PINS-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else if (s == 0) chain_q[s] <= pad_in;
         else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end

      // R6: each stage delays its predecessor by exactly one edge.
      if (s == 0) begin : g_first
         p_first_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (chain_q[0] == $past(pad_in)));
      end else begin : g_next
         p_next_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (chain_q[s] == $past(chain_q[s-1])));
      end
   end

   assign lvl_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_wr,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);

   localparam int HALF_W = DATA_W / 2;

   generate
      if (NUM_PINS != DATA_W) begin : g_width_chk
         $error("gpio_mask_port: NUM_PINS must equal DATA_W");
      end
      if ((DATA_W % 2) != 0) begin : g_even_chk
         $error("gpio_mask_port: DATA_W must be even");
      end
   endgenerate

   reg_sel_e            sel;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] lvl_sync;
   logic                set_stb, clr_stb, lo_stb, hi_stb;

   gpio_reg_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_decode (
      .addr    (bus_addr),
      .dir_vec (dir_q),
      .in_vec  (lvl_sync),
      .sel     (sel),
      .rdata   (bus_rdata)
   );

   assign set_stb = bus_wr && (sel == SEL_DIR_SET);
   assign clr_stb = bus_wr && (sel == SEL_DIR_CLR);
   assign lo_stb  = bus_wr && (sel == SEL_OUT_LO);
   assign hi_stb  = bus_wr && (sel == SEL_OUT_HI);

   gpio_dir_ctrl #(
      .NUM_PINS (NUM_PINS)
   ) u_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_stb),
      .clr_stb (clr_stb),
      .bits    (bus_wdata),
      .dir_q   (dir_q)
   );

   gpio_out_latch #(
      .NUM_PINS (NUM_PINS),
      .HALF_W   (HALF_W)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (lo_stb),
      .wr_hi (hi_stb),
      .wdata (bus_wdata),
      .out_q (pad_out)
   );

   gpio_in_sync #(
      .NUM_PINS (NUM_PINS),
      .STAGES   (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_in   (pad_in),
      .lvl_sync (lvl_sync)
   );

   assign pad_oe = dir_q;

   // R7: the direction word read back matches the enables on the pads.
   p_dir_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(bus_addr) == OFS_DIR_CLR) |-> (bus_rdata == pad_oe));

   // R8: turning pins on leaves the output levels untouched.
   p_no_glitch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb && !lo_stb && !hi_stb) |=> $stable(pad_out));

   // R9: writes to unmapped offsets change nothing.
   p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && bus_wr && sel inside {SEL_NONE, SEL_IN_LVL})
         |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out;
   logic [31:0] pad_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] dir_m = '0;
   logic [31:0] out_m = '0;
   logic [31:0] seed = 32'h1234_5678;

   always #10 clk = ~clk;

   gpio_mask_port i_gpio_mask_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   function automatic logic [31:0] next_pat(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic apply_half(input bit hi, input logic [31:0] d);
      for (int b = 0; b < 16; b++) begin
         if (d[16+b]) out_m[(hi ? 16 : 0) + b] = d[b];
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] prev_in;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 pad_oe", pad_oe, 32'h0);
      check("R1 pad_out", pad_out, 32'h0);
      bus_read(8'h04, v); check("R1 dir read", v, 32'h0);
      bus_read(8'h10, v); check("R1 in read", v, 32'h0);

      // R2 walking set, R7 readback
      for (int i = 0; i < 32; i++) begin
         bus_write(8'h00, 32'h1 << i);
         dir_m |= 32'h1 << i;
         check("R2 walk set", pad_oe, dir_m);
      end
      // R3 patterned clears, then patterned sets
      for (int k = 0; k < 24; k++) begin
         seed = next_pat(seed);
         if (k[0]) begin
            bus_write(8'h00, seed); dir_m |= seed;
            check("R2 pattern set", pad_oe, dir_m);
         end else begin
            bus_write(8'h04, seed); dir_m &= ~seed;
            check("R3 pattern clear", pad_oe, dir_m);
         end
         bus_read(8'h04, v); check("R7 dir read", v, dir_m);
      end
      for (int i = 0; i < 32; i++) begin
         bus_write(8'h00, 32'hFFFF_FFFF); dir_m = '1;
         bus_write(8'h04, 32'h1 << i); dir_m &= ~(32'h1 << i);
         check("R3 walk clear", pad_oe, dir_m);
      end

      // R4 / R5 masked updates
      for (int k = 0; k < 64; k++) begin
         seed = next_pat(seed);
         if (k[0]) begin
            bus_write(8'h0C, seed); apply_half(1'b1, seed);
            check("R5 high half", pad_out, out_m);
         end else begin
            bus_write(8'h08, seed); apply_half(1'b0, seed);
            check("R4 low half", pad_out, out_m);
         end
      end
      bus_write(8'h08, 32'h0000_FFFF);
      check("R4 zero mask holds", pad_out, out_m);
      bus_write(8'h0C, 32'hFFFF_0000); apply_half(1'b1, 32'hFFFF_0000);
      check("R5 full mask zeros", pad_out, out_m);

      // R8 preload while input, then enable
      bus_write(8'h04, 32'hFFFF_FFFF); dir_m = '0;
      bus_write(8'h08, 32'hFFFF_A5C3); apply_half(1'b0, 32'hFFFF_A5C3);
      bus_write(8'h0C, 32'hFFFF_3C5A); apply_half(1'b1, 32'hFFFF_3C5A);
      check("R8 preload oe off", pad_oe, 32'h0);
      check("R8 preload level", pad_out, out_m);
      @(negedge clk);
      bus_addr = 8'h00; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
      @(posedge clk); #1;
      check("R8 enable edge level", pad_out, out_m);
      @(negedge clk); bus_wr = 1'b0; dir_m = '1; #1;
      check("R8 enabled oe", pad_oe, dir_m);
      check("R8 enabled level", pad_out, out_m);

      // R6 synchronizer latency
      prev_in = 32'h0;
      for (int k = 0; k < 12; k++) begin
         seed = next_pat(seed);
         @(negedge clk);
         pad_in = seed; bus_addr = 8'h10;
         @(negedge clk); #1;
         check("R6 after one edge", bus_rdata, prev_in);
         @(negedge clk); #1;
         check("R6 after two edges", bus_rdata, seed);
         prev_in = seed;
      end

      // R9 unmapped offsets
      bus_write(8'h04, 32'h0F0F_0F0F); dir_m &= ~32'h0F0F_0F0F;
      bus_write(8'h14, 32'hFFFF_FFFF);
      bus_write(8'h02, 32'hFFFF_FFFF);
      bus_write(8'h10, 32'hFFFF_FFFF);
      bus_write(8'hFC, 32'hFFFF_0000);
      check("R9 ignored write oe", pad_oe, dir_m);
      check("R9 ignored write out", pad_out, out_m);
      bus_read(8'h14, v); check("R9 read 0x14", v, 32'h0);
      bus_read(8'h00, v); check("R9 read 0x00", v, 32'h0);
      bus_read(8'h08, v); check("R9 read 0x08", v, 32'h0);
      bus_read(8'h0C, v); check("R9 read 0x0C", v, 32'h0);
      bus_read(8'hFC, v); check("R9 read 0xFC", v, 32'h0);

      // R10 no strobe
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 32'hFFFF_FFFF;
      bus_addr = 8'h00; @(negedge clk);
      bus_addr = 8'h04; @(negedge clk);
      bus_addr = 8'h08; @(negedge clk);
      bus_addr = 8'h0C; @(negedge clk); #1;
      check("R10 idle oe", pad_oe, dir_m);
      check("R10 idle out", pad_out, out_m);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule